// File: doc/BRIEF.md
# Mesh Configuration Loader

This block moves a fresh set of routing configuration words from a host into the routers of a small mesh. It halts the whole network during the update. The host announces a reload with a single write strobe. The loader then withdraws the network-ready signal from every router and collects one word per router from the host, always in ascending router index. Each collected word goes into that router's own holding register, which drives the router's configuration port.

Word transfer uses a simple request/strobe exchange. The loader raises its request line. The host answers by presenting a word and pulsing its write strobe while the request is high. The loader accepts the word and drops the request for one cycle, then asks for the next word. Once the last router has its word, the network-ready signal returns to all routers at the same time. Traffic therefore never runs across a mesh that holds a mix of old and new routes. Working out the routes is the host's job.

Top module: `mesh_cfg_loader`

## Requirements
- R1: After reset, `net_ready_o` and `host_req_o` are low, every router word reads zero, and the loader waits for a host write before doing anything else.
- R2: A `host_wr_i` pulse seen while the loader is idle starts a load. `net_ready_o` is low from the next cycle until that load completes.
- R3: In the first cycle after the starting write, `host_req_o` stays low and `host_wr_i` is ignored. `host_req_o` rises in the second cycle after the starting write.
- R4: A word on `cfg_word_i` is accepted only at a clock edge where both `host_req_o` and `host_wr_i` are high. The k-th accepted word of a load (k counted from 0) appears on router slice k, `rtr_cfg_o[k*WORD_W +: WORD_W]`, in the following cycle.
- R5: `host_req_o` is low in the cycle after every accepted word. Between words it stays low for exactly one cycle. After the last word it stays low until the next load begins.
- R6: While a load is in progress, `host_wr_i` asserted when `host_req_o` is low changes no router word and does not restart the load or skip an index.
- R7: `net_ready_o` rises in the cycle after the last (NUM_RTR-th) word is accepted, and not earlier.
- R8: A router word holds its value in every cycle in which no word is accepted. A later load replaces all router words.
- R9: `host_req_o` is never high while `net_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe: starts a load when idle, qualifies a word when the request is high |
| cfg_word_i | input | WORD_W | Configuration word from the host |
| host_req_o | output | 1 | Request to the host for the next word |
| rtr_cfg_o | output | NUM_RTR*WORD_W | Holding registers of all routers, router k in slice k |
| net_ready_o | output | 1 | Network-ready level to all routers |

## Verification
On every cycle, the checker enforces the following: the request and ready relationship, the one-cycle request drop after each accepted word, and the ready drop after a starting write. It also checks that router words change only on an accepted word, and that ready rises only right after an acceptance. Only the bench scenarios can show the routing order of words to router slices and the count of nine before ready returns. The same applies to strobes during the settle and gap cycles being ignored without skipping an index, and to a second load fully replacing the first.

// File: rtl/mesh_cfg_pkg.sv
package mesh_cfg_pkg;
   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_ARM  = 2'd1,
      LD_ASK  = 2'd2,
      LD_GAP  = 2'd3
   } ld_state_e;
endpackage

// File: rtl/mesh_cfg_seq.sv
module mesh_cfg_seq
   import mesh_cfg_pkg::*;
#(
   parameter int NUM_RTR = 9,
   parameter int IDX_W   = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             host_wr_i,
   output logic             req_o,
   output logic             ready_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] idx_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RTR - 1);

   ld_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic             ready_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= LD_IDLE;
         idx_q   <= '0;
         ready_q <= 1'b0;
      end else begin
         unique case (state_q)
            LD_IDLE: begin
               if (host_wr_i) begin
                  state_q <= LD_ARM;
                  idx_q   <= '0;
                  ready_q <= 1'b0;
               end
            end
            LD_ARM: state_q <= LD_ASK;
            LD_ASK: begin
               if (host_wr_i) begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= LD_IDLE;
                     ready_q <= 1'b1;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= LD_GAP;
                  end
               end
            end
            default: state_q <= LD_ASK;
         endcase
      end
   end

   assign req_o   = (state_q == LD_ASK);
   assign wr_en_o = req_o && host_wr_i;
   assign ready_o = ready_q;
   assign idx_o   = idx_q;
endmodule

// File: rtl/mesh_cfg_bank.sv
module mesh_cfg_bank #(
   parameter int NUM_RTR = 9,
   parameter int WORD_W  = 18,
   parameter int IDX_W   = 4
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_en_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [WORD_W-1:0]         word_i,
   output logic [NUM_RTR*WORD_W-1:0] bank_o
);
   for (genvar r = 0; r < NUM_RTR; r++) begin : g_rtr
      logic [WORD_W-1:0] hold_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            hold_q <= '0;
         end else if (wr_en_i && (idx_i == IDX_W'(r))) begin
            hold_q <= word_i;
         end
      end
      assign bank_o[r*WORD_W +: WORD_W] = hold_q;
   end
endmodule

// File: rtl/mesh_cfg_loader.sv
module mesh_cfg_loader #(
   parameter int NUM_RTR = 9,
   parameter int WORD_W  = 18
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      host_wr_i,
   input  logic [WORD_W-1:0]         cfg_word_i,
   output logic                      host_req_o,
   output logic [NUM_RTR*WORD_W-1:0] rtr_cfg_o,
   output logic                      net_ready_o
);
   localparam int IDX_W = (NUM_RTR > 1) ? $clog2(NUM_RTR) : 1;

   if (NUM_RTR < 1) begin : g_bad_count
      $error("mesh_cfg_loader: NUM_RTR must be at least 1");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("mesh_cfg_loader: WORD_W must be at least 1");
   end

   logic             wr_en;
   logic [IDX_W-1:0] idx;

   mesh_cfg_seq #(.NUM_RTR(NUM_RTR), .IDX_W(IDX_W)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .host_wr_i (host_wr_i),
      .req_o     (host_req_o),
      .ready_o   (net_ready_o),
      .wr_en_o   (wr_en),
      .idx_o     (idx)
   );

   mesh_cfg_bank #(.NUM_RTR(NUM_RTR), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en),
      .idx_i   (idx),
      .word_i  (cfg_word_i),
      .bank_o  (rtr_cfg_o)
   );
endmodule

// File: rtl/mesh_cfg_loader_chk.sv
module mesh_cfg_loader_chk #(
   parameter int NUM_RTR = 9,
   parameter int WORD_W  = 18
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      host_wr_i,
   input logic                      host_req_o,
   input logic [NUM_RTR*WORD_W-1:0] rtr_cfg_o,
   input logic                      net_ready_o
);
   p_req_vs_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      net_ready_o |-> !host_req_o);

   p_req_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_req_o && host_wr_i) |=> !host_req_o);

   p_ready_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (net_ready_o && host_wr_i) |=> !net_ready_o);

   p_settle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (net_ready_o && host_wr_i) |=> !host_req_o);

   p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_req_o && host_wr_i) |=> $stable(rtr_cfg_o));

   p_ready_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(net_ready_o) |-> $past(host_req_o && host_wr_i));
endmodule

bind mesh_cfg_loader mesh_cfg_loader_chk #(.NUM_RTR(NUM_RTR), .WORD_W(WORD_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .host_wr_i   (host_wr_i),
   .host_req_o  (host_req_o),
   .rtr_cfg_o   (rtr_cfg_o),
   .net_ready_o (net_ready_o)
);

// File: tb/mesh_cfg_loader_bench.sv
`timescale 1ns/1ps
module mesh_cfg_loader_bench;
   localparam int N = 9;
   localparam int W = 18;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr = 1'b0;
   logic [W-1:0]   word = '0;
   logic           req;
   logic [N*W-1:0] cfg;
   logic           ready;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int           exp_idx_q[$];
   logic [W-1:0] exp_word_q[$];
   logic [W-1:0] model [N];

   always #4 clk = ~clk;

   mesh_cfg_loader #(.NUM_RTR(N), .WORD_W(W)) u_mesh_cfg_loader (
      .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .cfg_word_i(word),
      .host_req_o(req), .rtr_cfg_o(cfg), .net_ready_o(ready)
   );

   task automatic check(input bit ok, input string rq, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // monitor: pops expected words and compares the router slice
   initial begin
      forever begin
         @(negedge clk);
         while (exp_idx_q.size() > 0) begin
            int k;
            logic [W-1:0] w;
            k = exp_idx_q.pop_front();
            w = exp_word_q.pop_front();
            check(cfg[k*W +: W] == w, "R4 word in router slice", 32'(cfg[k*W +: W]), 32'(w));
         end
      end
   end

   // driver: one full load; optional stray strobes in settle and gap cycles
   task automatic load_all(input logic [W-1:0] base, input bit stray);
      @(negedge clk);
      wr = 1'b1;
      word = ~base;
      @(negedge clk);
      check(ready == 1'b0, "R2 ready low after write", 32'(ready), 0);
      check(req == 1'b0, "R3 no request in settle cycle", 32'(req), 0);
      if (!stray) wr = 1'b0;
      @(negedge clk);
      wr = 1'b0;
      check(req == 1'b1, "R3 request two cycles after write", 32'(req), 1);
      check(cfg[0 +: W] == model[0], "R6 settle strobe ignored", 32'(cfg[0 +: W]), 32'(model[0]));
      for (int k = 0; k < N; k++) begin
         while (req !== 1'b1) @(negedge clk);
         wr = 1'b1;
         word = base + W'(k * 37);
         @(posedge clk);
         model[k] = base + W'(k * 37);
         exp_idx_q.push_back(k);
         exp_word_q.push_back(model[k]);
         @(negedge clk);
         wr = 1'b0;
         check(req == 1'b0, "R5 request low after accepted word", 32'(req), 0);
         if (k < N - 1) begin
            check(ready == 1'b0, "R7 ready still low mid-load", 32'(ready), 0);
            if (stray) begin
               wr = 1'b1;
               word = ~base;
               @(negedge clk);
               wr = 1'b0;
               check(req == 1'b1, "R5 request back after one gap cycle", 32'(req), 1);
               check(cfg[(k+1)*W +: W] == model[k+1], "R6 gap strobe ignored",
                     32'(cfg[(k+1)*W +: W]), 32'(model[k+1]));
            end
         end else begin
            check(ready == 1'b1, "R7 ready after last word", 32'(ready), 1);
         end
      end
      @(negedge clk);
      check(req == 1'b0, "R5 request stays low after load", 32'(req), 0);
      check(ready == 1'b1, "R9 ready held with request low", 32'(ready), 1);
   endtask

   initial begin
      for (int k = 0; k < N; k++) model[k] = '0;
      repeat (3) @(negedge clk);
      check(ready == 1'b0, "R1 ready low in reset", 32'(ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b0, "R1 ready low after reset", 32'(ready), 0);
      check(req == 1'b0, "R1 request low after reset", 32'(req), 0);
      check(cfg == '0, "R1 router words zero", 32'(cfg[31:0]), 0);
      repeat (4) @(negedge clk);
      check(req == 1'b0 && ready == 1'b0, "R1 waits for host write", 32'({req, ready}), 0);

      load_all(18'h01234, 1'b0);
      repeat (5) @(negedge clk);
      for (int k = 0; k < N; k++)
         check(cfg[k*W +: W] == model[k], "R8 words hold while idle", 32'(cfg[k*W +: W]), 32'(model[k]));

      load_all(18'h2A5C0, 1'b1);
      @(negedge clk);
      for (int k = 0; k < N; k++)
         check(cfg[k*W +: W] == model[k], "R8 second load replaces all", 32'(cfg[k*W +: W]), 32'(model[k]));

      load_all(18'h3FFF0, 1'b0);
      repeat (2) @(negedge clk);
      for (int k = 0; k < N; k++)
         check(cfg[k*W +: W] == model[k], "R4 third load order", 32'(cfg[k*W +: W]), 32'(model[k]));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule